// File: doc/BRIEF.md
# Status register masked immediate writer

This block executes one kind of instruction: a move of an immediate constant into a program status register. It decodes a 32-bit instruction word, expands the 12-bit immediate field into a 32-bit value, and writes the byte lanes picked by a 4-bit field mask. The destination is either the current status register or the saved status register that belongs to the current processor mode. The block holds the current status register and one saved register for each of the five privileged banked modes: FIQ, IRQ, Supervisor, Abort and Undefined. It takes the current mode from the mode field of its own current status register.

Three cases raise a one-cycle flag instead of completing the write. An encoding that belongs to the hint decoder raises the hint flag. An encoding the block must not execute raises the unpredictable flag. A mode value that cannot be entered raises the illegal-execution flag. The surrounding core supplies the instruction word, a valid strobe and the condition-passed result. It acts on the flags and reads the registers directly.

Top module: `psr_imm_writer`

## Requirements
- R1: An instruction is recognised only when `insn_vld_i` is high, bits 31:28 are not 1111, bits 27:23 equal 00110 and bits 21:20 equal 10. Any other word changes no register and raises no flag. Bits 15:12 have no effect.
- R2: When `cond_pass_i` is low, no register changes, and neither the unpredictable flag nor the illegal flag rises.
- R3: The written value is the low 8 bits of the immediate field, zero-extended to 32 bits and rotated right by twice the value of bits 11:8.
- R4: Mask bit k (instruction bit 16+k) enables destination bits 8k+7 down to 8k. Mask 1000 writes only the flag byte (bits 31:24). Mask 0100 writes only the GE byte (bits 23:16). Mask 1100 writes both.
- R5: Bit 22 selects the destination: 0 for the current register, 1 for the saved register of the current mode. Saved registers appear on `spsr_o` in 32-bit slots in the order FIQ (bits 31:0), IRQ, Supervisor, Abort, Undefined (bits 159:128).
- R6: Mask 0000 with bit 22 clear pulses `hint_o` whatever `cond_pass_i` is, and writes nothing.
- R7: Mask 0000 with bit 22 set pulses `unpred_o` and writes nothing.
- R8: A saved-register write attempted in User mode (10000) or System mode (11111) pulses `unpred_o` and writes nothing.
- R9: The mode field is bits 4:0. The legal values are 10000, 10001, 10010, 10011, 10111, 11011 and 11111. A privileged write with mask bit 0 set and an illegal mode value pulses `illegal_o`. In that case bits 4:0 keep their old value, and all other enabled bits are still written.
- R10: In User mode, a current-register write can change only bits 31:24 (mask bit 3), bits 19:16 (mask bit 2) and the endianness bit 9 (mask bit 1). Bit 9 is writable in every mode.
- R11: Reset sets the current register to 0x00000013 (Supervisor) and every saved register to zero. Each flag is registered, so it is high only in the cycle after the instruction that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| insn_vld_i | input | 1 | Instruction word is valid this cycle |
| insn_i | input | 32 | Instruction word |
| cond_pass_i | input | 1 | Condition check of the instruction passed |
| cpsr_o | output | 32 | Current status register |
| spsr_o | output | 160 | Five saved status registers, FIQ in the low slot |
| unpred_o | output | 1 | Unpredictable encoding or context, write suppressed |
| illegal_o | output | 1 | Illegal mode value, mode field kept |
| hint_o | output | 1 | Encoding belongs to the hint decoder |

## Verification
The bench sweeps every legal mode, every mask, both destinations, both values of `cond_pass_i` and a set of immediates. Before each vector it fills every byte of the registers with known values, so a wrong lane enable shows up as a changed or stale byte. The immediates include an illegal mode value, a legal mode change and rotations that put bits into two lanes. A design that updated the mode on an illegal value, let User mode write the mode byte, wrote a saved register from System mode, or rotated by the field value instead of twice it would each produce a register that differs from the computed one. Directed cases cover the undefined condition code, a wrong opcode field, a dropped valid strobe, all sixteen rotations, and flags that do not clear after one cycle.

// File: rtl/psr_imm_pkg.sv
package psr_imm_pkg;

    localparam int PSR_W      = 32;
    localparam int LANE_W     = 8;
    localparam int NUM_LANES  = PSR_W / LANE_W;
    localparam int NUM_BANKS  = 5;
    localparam int BANK_IDX_W = $clog2(NUM_BANKS);
    localparam int MODE_W     = 5;
    localparam int IMM_W      = 12;

    typedef logic [MODE_W-1:0] mode_t;

    localparam mode_t MODE_USR = 5'b10000;
    localparam mode_t MODE_FIQ = 5'b10001;
    localparam mode_t MODE_IRQ = 5'b10010;
    localparam mode_t MODE_SVC = 5'b10011;
    localparam mode_t MODE_ABT = 5'b10111;
    localparam mode_t MODE_UND = 5'b11011;
    localparam mode_t MODE_SYS = 5'b11111;

    // bits that unprivileged code may change: flag byte, GE nibble, endianness
    localparam logic [PSR_W-1:0] USER_ALLOW = 32'hFF0F_0200;

    typedef struct packed {
        logic              hit;       // executable form of the instruction
        logic              hint;      // handed to the hint decoder
        logic              to_saved;  // destination is the banked saved register
        logic [NUM_LANES-1:0] mask;
        logic [PSR_W-1:0]  value;
    } dec_t;

    function automatic logic mode_is_legal(input mode_t m);
        case (m)
            MODE_USR, MODE_FIQ, MODE_IRQ, MODE_SVC,
            MODE_ABT, MODE_UND, MODE_SYS: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

    function automatic logic [BANK_IDX_W-1:0] bank_of(input mode_t m);
        case (m)
            MODE_FIQ: return BANK_IDX_W'(0);
            MODE_IRQ: return BANK_IDX_W'(1);
            MODE_ABT: return BANK_IDX_W'(3);
            MODE_UND: return BANK_IDX_W'(4);
            default:  return BANK_IDX_W'(2);
        endcase
    endfunction

    function automatic logic [PSR_W-1:0] expand_imm(input logic [IMM_W-1:0] f);
        logic [2*PSR_W-1:0] twice;
        logic [2*PSR_W-1:0] shifted;
        logic [5:0]         amt;
        twice   = {2{{(PSR_W-8){1'b0}}, f[7:0]}};
        amt     = {1'b0, f[11:8], 1'b0};
        shifted = twice >> amt;
        return shifted[PSR_W-1:0];
    endfunction

endpackage

// File: rtl/psr_imm_decode.sv
module psr_imm_decode
    import psr_imm_pkg::*;
(
    input  logic             vld_i,
    input  logic [PSR_W-1:0] insn_i,
    output dec_t             dec_o
);

    logic pattern_ok;
    logic mask_zero;
    logic sbo_unused;

    // should-be-one field carries no meaning here
    assign sbo_unused = ^insn_i[15:12];

    always_comb begin
        pattern_ok = vld_i
                  && (insn_i[31:28] != 4'b1111)
                  && (insn_i[27:23] == 5'b00110)
                  && (insn_i[21:20] == 2'b10);
        mask_zero  = (insn_i[19:16] == 4'b0000);

        dec_o.to_saved = insn_i[22];
        dec_o.mask     = insn_i[19:16];
        dec_o.value    = expand_imm(insn_i[IMM_W-1:0]);
        dec_o.hint     = pattern_ok && mask_zero && !insn_i[22];
        dec_o.hit      = pattern_ok && !(mask_zero && !insn_i[22]);
    end

endmodule

// File: rtl/psr_lane_merge.sv
module psr_lane_merge #(
    parameter  int LANE_W    = 8,
    parameter  int NUM_LANES = 4,
    localparam int W         = LANE_W * NUM_LANES
) (
    input  logic [W-1:0]         old_i,
    input  logic [W-1:0]         new_i,
    input  logic [W-1:0]         allow_i,
    input  logic [NUM_LANES-1:0] lane_en_i,
    output logic [W-1:0]         merged_o
);

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [LANE_W-1:0] o, n, a;
        assign o = old_i  [l*LANE_W +: LANE_W];
        assign n = new_i  [l*LANE_W +: LANE_W];
        assign a = allow_i[l*LANE_W +: LANE_W];
        assign merged_o[l*LANE_W +: LANE_W] = lane_en_i[l] ? ((n & a) | (o & ~a)) : o;
    end

endmodule

// File: rtl/psr_imm_writer.sv
module psr_imm_writer
    import psr_imm_pkg::*;
#(
    parameter mode_t RESET_MODE = MODE_SVC
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       insn_vld_i,
    input  logic [PSR_W-1:0]           insn_i,
    input  logic                       cond_pass_i,
    output logic [PSR_W-1:0]           cpsr_o,
    output logic [NUM_BANKS*PSR_W-1:0] spsr_o,
    output logic                       unpred_o,
    output logic                       illegal_o,
    output logic                       hint_o
);

    typedef struct packed {
        logic [NUM_BANKS-1:0][PSR_W-1:0] spsr;
        logic [PSR_W-1:0]                cpsr;
        logic                            unpred;
        logic                            illegal;
        logic                            hint;
    } st_t;

    localparam st_t ST_RST = '{
        spsr:    '0,
        cpsr:    {{(PSR_W-MODE_W){1'b0}}, RESET_MODE},
        unpred:  1'b0,
        illegal: 1'b0,
        hint:    1'b0
    };

    st_t  state_q, state_d;
    dec_t dec;

    mode_t                 cur_mode;
    logic                  in_user, in_system, mode_bad;
    logic [BANK_IDX_W-1:0] bank;
    logic [PSR_W-1:0]      cpsr_allow, cpsr_merged, spsr_cur, spsr_merged;

    psr_imm_decode u_dec (
        .vld_i  (insn_vld_i),
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    always_comb begin
        cur_mode   = state_q.cpsr[MODE_W-1:0];
        in_user    = (cur_mode == MODE_USR);
        in_system  = (cur_mode == MODE_SYS);
        bank       = bank_of(cur_mode);
        spsr_cur   = state_q.spsr[bank];
        mode_bad   = !in_user && dec.mask[0] && !mode_is_legal(dec.value[MODE_W-1:0]);
        cpsr_allow = in_user ? USER_ALLOW : '1;
        if (mode_bad) cpsr_allow[MODE_W-1:0] = '0;
    end

    psr_lane_merge #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_cpsr_merge (
        .old_i     (state_q.cpsr),
        .new_i     (dec.value),
        .allow_i   (cpsr_allow),
        .lane_en_i (dec.mask),
        .merged_o  (cpsr_merged)
    );

    psr_lane_merge #(.LANE_W(LANE_W), .NUM_LANES(NUM_LANES)) u_spsr_merge (
        .old_i     (spsr_cur),
        .new_i     (dec.value),
        .allow_i   ('1),
        .lane_en_i (dec.mask),
        .merged_o  (spsr_merged)
    );

    always_comb begin
        state_d         = state_q;
        state_d.unpred  = 1'b0;
        state_d.illegal = 1'b0;
        state_d.hint    = dec.hint;
        if (dec.hit && cond_pass_i) begin
            if (dec.to_saved) begin
                if (dec.mask == '0 || in_user || in_system)
                    state_d.unpred = 1'b1;
                else
                    state_d.spsr[bank] = spsr_merged;
            end else begin
                state_d.cpsr    = cpsr_merged;
                state_d.illegal = mode_bad;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RST;
        else        state_q <= state_d;
    end

    assign cpsr_o    = state_q.cpsr;
    assign spsr_o    = state_q.spsr;
    assign unpred_o  = state_q.unpred;
    assign illegal_o = state_q.illegal;
    assign hint_o    = state_q.hint;

    // R6 R7
    hint_unpred_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hint_o && unpred_o));

    // R2
    no_cond_no_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cond_pass_i |=> ($stable(cpsr_o) && $stable(spsr_o) && !unpred_o && !illegal_o));

    // R9
    mode_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_is_legal(cpsr_o[MODE_W-1:0]));

    // R9
    illegal_keeps_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> (cpsr_o[MODE_W-1:0] == $past(cpsr_o[MODE_W-1:0])));

    // R8
    unpred_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unpred_o |-> ($stable(spsr_o) && $stable(cpsr_o)));

    // R10
    user_protect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cpsr_o[MODE_W-1:0]) == MODE_USR)
            |-> (((cpsr_o ^ $past(cpsr_o)) & ~USER_ALLOW) == '0));

endmodule

// File: tb/psr_imm_writer_test.sv
module psr_imm_writer_test;

    localparam int CLK_PERIOD = 10;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         insn_vld_i = 1'b0;
    logic [31:0]  insn_i = '0;
    logic         cond_pass_i = 1'b0;
    logic [31:0]  cpsr_o;
    logic [159:0] spsr_o;
    logic         unpred_o, illegal_o, hint_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    psr_imm_writer uut (
        .clk, .rst_n, .insn_vld_i, .insn_i, .cond_pass_i,
        .cpsr_o, .spsr_o, .unpred_o, .illegal_o, .hint_o
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [31:0] m_cpsr;
    logic [31:0] m_spsr [5];
    logic        m_unp, m_ill, m_hint;

    function automatic logic legal(input logic [4:0] m);
        return m == 5'b10000 || m == 5'b10001 || m == 5'b10010 || m == 5'b10011
            || m == 5'b10111 || m == 5'b11011 || m == 5'b11111;
    endfunction

    function automatic int bank_idx(input logic [4:0] m);
        case (m)
            5'b10001: return 0;
            5'b10010: return 1;
            5'b10111: return 3;
            5'b11011: return 4;
            default:  return 2;
        endcase
    endfunction

    // R3: rotate one bit at a time, twice per step of the rotate field
    function automatic logic [31:0] expand(input logic [11:0] f);
        logic [31:0] v = {24'b0, f[7:0]};
        for (int i = 0; i < 2 * int'(f[11:8]); i++) v = {v[0], v[31:1]};
        return v;
    endfunction

    function automatic logic [31:0] mk_insn(input logic [3:0] c, input logic r,
                                            input logic [3:0] mk, input logic [11:0] imm);
        return {c, 5'b00110, r, 2'b10, mk, 4'hF, imm};
    endfunction

    task automatic model_apply(input logic [31:0] w, input logic cp, input logic v);
        logic        pat, r, usr;
        logic [3:0]  mk;
        logic [31:0] val, allow;
        logic [4:0]  md;
        m_unp = 0; m_ill = 0; m_hint = 0;
        pat = v && w[31:28] != 4'hF && w[27:23] == 5'b00110 && w[21:20] == 2'b10;
        r   = w[22];
        mk  = w[19:16];
        val = expand(w[11:0]);
        md  = m_cpsr[4:0];
        usr = (md == 5'b10000);
        if (pat && mk == 0 && !r) m_hint = 1;
        else if (pat && cp) begin
            if (r) begin
                if (mk == 0 || usr || md == 5'b11111) m_unp = 1;
                else for (int i = 0; i < 32; i++)
                    if (mk[i/8]) m_spsr[bank_idx(md)][i] = val[i];
            end else begin
                allow = usr ? 32'hFF0F_0200 : 32'hFFFF_FFFF;
                if (!usr && mk[0] && !legal(val[4:0])) begin
                    m_ill = 1;
                    allow[4:0] = 0;
                end
                for (int i = 0; i < 32; i++)
                    if (mk[i/8] && allow[i]) m_cpsr[i] = val[i];
            end
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 0; insn_vld_i = 0; cond_pass_i = 0;
        @(negedge clk);
        rst_n = 1;
        m_cpsr = 32'h13;
        for (int b = 0; b < 5; b++) m_spsr[b] = '0;
        m_unp = 0; m_ill = 0; m_hint = 0;
    endtask

    task automatic issue(input logic [31:0] w, input logic cp, input logic v);
        @(negedge clk);
        insn_i = w; cond_pass_i = cp; insn_vld_i = v;
        model_apply(w, cp, v);
        @(negedge clk);
        insn_vld_i = 0; cond_pass_i = 0;
    endtask

    task automatic chk(input string tag, input logic [159:0] act, input logic [159:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk(tag, {128'b0, cpsr_o}, {128'b0, m_cpsr});
        chk(tag, spsr_o, {m_spsr[4], m_spsr[3], m_spsr[2], m_spsr[1], m_spsr[0]});
        chk(tag, {157'b0, unpred_o, illegal_o, hint_o}, {157'b0, m_unp, m_ill, m_hint});
    endtask

    // fill every byte with known data, then enter mode m
    task automatic prepare(input logic [4:0] m);
        do_reset();
        issue(mk_insn(4'hE, 0, 4'b0010, {4'hC, 8'h6E}), 1, 1);
        issue(mk_insn(4'hE, 0, 4'b0100, {4'h8, 8'hA9}), 1, 1);
        issue(mk_insn(4'hE, 0, 4'b1000, {4'h4, 8'h53}), 1, 1);
        if (m != 5'b10011) issue(mk_insn(4'hE, 0, 4'b0001, {4'h0, 3'b110, m}), 1, 1);
        if (m != 5'b10000 && m != 5'b11111) begin
            issue(mk_insn(4'hE, 1, 4'b0001, {4'h0, 8'h3C}), 1, 1);
            issue(mk_insn(4'hE, 1, 4'b0010, {4'hC, 8'hC5}), 1, 1);
            issue(mk_insn(4'hE, 1, 4'b0100, {4'h8, 8'h96}), 1, 1);
            issue(mk_insn(4'hE, 1, 4'b1000, {4'h4, 8'h7B}), 1, 1);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R11 watchdog actual=running expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [4:0]  modes [7];
        logic [11:0] imms [5];
        string       tag;
        modes = '{5'b10000, 5'b10001, 5'b10010, 5'b10011, 5'b10111, 5'b11011, 5'b11111};
        imms  = '{12'h0D7, 12'h015, 12'h4F1, 12'hB3C, 12'h1FF};

        // R11 reset state
        do_reset();
        check_all("R11");

        // R1 rejected words and dropped strobe
        prepare(5'b10011);
        issue(mk_insn(4'hF, 0, 4'b1000, 12'h0FF), 1, 1);
        check_all("R1");
        issue(mk_insn(4'hE, 0, 4'b1000, 12'h0FF) & ~32'h0020_0000, 1, 1);
        check_all("R1");
        issue(mk_insn(4'hE, 0, 4'b1000, 12'h0FF), 1, 0);
        check_all("R1");
        issue(mk_insn(4'hE, 0, 4'b1000, 12'h0FF) & ~32'h0000_F000, 1, 1);
        check_all("R1");

        // R3 every rotation
        for (int rot = 0; rot < 16; rot++) begin
            issue(mk_insn(4'hE, 0, 4'b1110, {rot[3:0], 8'h81}), 1, 1);
            check_all("R3");
        end

        // R11 flag lasts one cycle
        issue(mk_insn(4'hE, 1, 4'b0000, 12'h000), 1, 1);
        check_all("R7");
        @(negedge clk);
        m_unp = 0;
        check_all("R11");

        // sweep
        for (int mi = 0; mi < 7; mi++)
            for (int mk = 0; mk < 16; mk++)
                for (int r = 0; r < 2; r++)
                    for (int ii = 0; ii < 5; ii++)
                        for (int cp = 0; cp < 2; cp++) begin
                            logic [4:0] md;
                            md = modes[mi];
                            prepare(md);
                            if (cp == 0 && !(mk == 0 && r == 0)) tag = "R2";
                            else if (mk == 0 && r == 0) tag = "R6";
                            else if (mk == 0) tag = "R7";
                            else if (r == 1 && (md == 5'b10000 || md == 5'b11111)) tag = "R8";
                            else if (r == 1) tag = "R5";
                            else if (md == 5'b10000) tag = "R10";
                            else if (mk[0] && !legal(expand(imms[ii]) & 5'h1F)) tag = "R9";
                            else tag = "R4";
                            issue(mk_insn(4'hE, r[0], mk[3:0], imms[ii]), cp[0], 1);
                            check_all(tag);
                        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule